// File: doc/BRIEF.md
# Capacitive Touch Charge-Cycle Sensor

This block runs a relaxation-style touch pad that hangs on a single bidirectional pin with an external pull resistor. The controller tops up the pad by driving the pin for a short pulse. It then releases the pin and waits for the synchronized pad level to change. Each change it sees is counted, and each one starts another recharge pulse. A finger raises the pad capacitance, which slows every discharge, so fewer cycles fit into a sensing window of fixed length.

When a window closes, the controller compares the number of cycles it collected with a threshold supplied on a port. It publishes a touched flag and the raw cycle count together, marked by a strobe one cycle wide. The raw count lets the threshold be tuned to the pad and resistor actually fitted. Both times are given in system clock cycles. The default window is 25 ms at a 200 MHz clock. The default pulse is 1 µs. A 50 ms window and a threshold near 12000 are also valid settings. The pulse must be at least three cycles long, so that the synchronizer has settled before listening resumes.

The controller has four states:
- ST_PRECHARGE: the pin is driven at the start of every window.
- ST_LISTEN: the pin is released, and the controller waits for a pad change.
- ST_RECHARGE: the pin is driven again after a change has been counted.
- ST_REPORT: a single cycle that latches the results.

It moves between them as follows:
- ST_PRECHARGE goes to ST_LISTEN when the pulse ends.
- ST_LISTEN goes to ST_RECHARGE when a change is detected.
- ST_RECHARGE goes to ST_LISTEN when the pulse ends.
- Any of those three states goes to ST_REPORT when the window ends. The end of the window takes priority over every other transition.
- ST_REPORT always goes to ST_PRECHARGE.

Reset places the controller in ST_PRECHARGE.

Top module: `touch_cycle_sensor`

## Requirements
- R1: While reset is held, and directly after it, pad_oe is 1 and raw_count, touched and count_valid are all 0.
- R2: Every window starts in ST_PRECHARGE with the cycle counter at zero. The pin is driven (pad_oe=1) for RECHARGE_CYC cycles before the first listening cycle.
- R3: The pad input passes through a two-flop synchronizer. While listening, each change of the synchronized level adds one to the counter. That change also starts a recharge pulse of RECHARGE_CYC driven cycles, after which the pin is released again. A slower-discharging pad therefore gives a lower count.
- R4: Pad changes that occur while the pin is driven are not counted.
- R5: A window lasts WINDOW_CYC cycles and is followed by one report cycle, so count_valid pulses every WINDOW_CYC+1 cycles.
- R6: touched is 1 when the window's count is strictly below touch_limit, sampled in the report cycle. A count equal to touch_limit gives touched=0.
- R7: raw_count presents the count of each completed window.
- R8: The counter saturates at 2^CNT_W-1 and never wraps. Counts below that limit are reported exactly.
- R9: count_valid is high for exactly one cycle per window. raw_count and touched change only together with it and hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_in | input | 1 | Pad level read back from the pin |
| pad_oe | output | 1 | Drive enable for the pin (driven level is the charged level) |
| touch_limit | input | CNT_W | Count below which a touch is reported |
| raw_count | output | CNT_W | Cycle count of the last completed window |
| count_valid | output | 1 | One-cycle strobe marking new results |
| touched | output | 1 | Touch decision of the last completed window |

## Verification
The pad is modelled with three discharge delays: one cycle (an untouched pad), twelve cycles (a light touch) and forty cycles (a heavy touch). Comparing the first two shows that a slower pad lowers the count and flips the decision. The forty-cycle case shows that a narrow counter reports exactly while it stays under its limit. The one-cycle case drives that same narrow counter into saturation, where a wrap would show up as a small value. A further pattern injects a bounce while the pin is driven, and its count must equal the clean count. Setting the threshold to the observed count, and then to that count plus one, pins down the strict comparison.

// File: rtl/touch_sense_pkg.sv
package touch_sense_pkg;

    typedef enum logic [1:0] {
        ST_PRECHARGE = 2'd0,
        ST_LISTEN    = 2'd1,
        ST_RECHARGE  = 2'd2,
        ST_REPORT    = 2'd3
    } sense_state_t;

endpackage

// File: rtl/touch_pad_sync.sv
// Synchronizes the pad level and flags any change of the synchronized value.
module touch_pad_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_raw,
    output logic pad_changed
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], pad_raw};
        end
    end

    assign pad_changed = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/touch_span_timer.sv
// Counts cycles while run is high and flags the last cycle of a LIMIT-long span.
module touch_span_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic at_end
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] ticks;

    assign at_end = run && (ticks == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks <= '0;
        end else if (!run || at_end) begin
            ticks <= '0;
        end else begin
            ticks <= ticks + 1'b1;
        end
    end
endmodule

// File: rtl/touch_sat_counter.sv
// Event counter that clears on request and sticks at its maximum value.
module touch_sat_counter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] CEILING = {WIDTH{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clear) begin
            value <= '0;
        end else if (bump && (value != CEILING)) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/touch_cycle_sensor.sv
module touch_cycle_sensor #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned WINDOW_CYC   = 5_000_000,
    parameter int unsigned RECHARGE_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_in,
    output logic             pad_oe,
    input  logic [CNT_W-1:0] touch_limit,
    output logic [CNT_W-1:0] raw_count,
    output logic             count_valid,
    output logic             touched
);
    import touch_sense_pkg::*;

    localparam int unsigned SYNC_STAGES = 2;

    sense_state_t     state;
    sense_state_t     next_state;
    logic             pad_changed;
    logic             window_end;
    logic             pulse_end;
    logic             in_report;
    logic [CNT_W-1:0] live_count;

    assign in_report = (state == ST_REPORT);

    touch_pad_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .pad_raw     (pad_in),
        .pad_changed (pad_changed)
    );

    touch_span_timer #(
        .LIMIT (WINDOW_CYC)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (!in_report),
        .at_end (window_end)
    );

    touch_span_timer #(
        .LIMIT (RECHARGE_CYC)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (pad_oe),
        .at_end (pulse_end)
    );

    touch_sat_counter #(
        .WIDTH (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (in_report),
        .bump  ((state == ST_LISTEN) && pad_changed),
        .value (live_count)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PRECHARGE;
        end else begin
            state <= next_state;
        end
    end

    // Transitions; the end of the window overrides every other move
    always_comb begin
        next_state = state;
        unique case (state)
            ST_PRECHARGE, ST_RECHARGE: begin
                if (window_end)     next_state = ST_REPORT;
                else if (pulse_end) next_state = ST_LISTEN;
            end
            ST_LISTEN: begin
                if (window_end)       next_state = ST_REPORT;
                else if (pad_changed) next_state = ST_RECHARGE;
            end
            ST_REPORT: next_state = ST_PRECHARGE;
            default:   next_state = ST_PRECHARGE;
        endcase
    end

    // Outputs: pin drive follows the state, results latch in the report cycle
    always_comb begin
        pad_oe = (state == ST_PRECHARGE) || (state == ST_RECHARGE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_count   <= '0;
            touched     <= 1'b0;
            count_valid <= 1'b0;
        end else begin
            count_valid <= in_report;
            if (in_report) begin
                raw_count <= live_count;
                touched   <= (live_count < touch_limit);
            end
        end
    end
endmodule

// File: rtl/touch_cycle_sensor_checker.sv
module touch_cycle_sensor_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        pad_oe,
    input logic [CNT_W-1:0]            touch_limit,
    input logic [CNT_W-1:0]            raw_count,
    input logic                        count_valid,
    input logic                        touched,
    input logic [CNT_W-1:0]            live_count,
    input touch_sense_pkg::sense_state_t state
);
    import touch_sense_pkg::*;

    localparam logic [CNT_W-1:0] CEILING = {CNT_W{1'b1}};

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid |=> !count_valid);

    assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !count_valid |-> ($stable(raw_count) && $stable(touched)));

    assert_window_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid |-> (pad_oe && (live_count == '0)));

    assert_touch_decision_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid |-> (touched == (raw_count < $past(touch_limit))));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_count == CEILING) && (state != ST_REPORT)) |=> (live_count == CEILING));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_REPORT) |=> (({1'b0, live_count} == {1'b0, $past(live_count)}) ||
                                  ({1'b0, live_count} == ({1'b0, $past(live_count)} + 1'b1))));
endmodule

bind touch_cycle_sensor touch_cycle_sensor_checker #(.CNT_W(CNT_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pad_oe      (pad_oe),
    .touch_limit (touch_limit),
    .raw_count   (raw_count),
    .count_valid (count_valid),
    .touched     (touched),
    .live_count  (live_count),
    .state       (state)
);

// File: tb/touch_cycle_sensor_test.sv
`timescale 1ns/1ps
module touch_cycle_sensor_test;
    localparam int W   = 5;
    localparam int WS  = 3;
    localparam int WIN = 200;
    localparam int RC  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pad_in = 1'b1;
    logic [W-1:0]  thr = 5'd20;
    logic [WS-1:0] thr_s = 3'd5;
    logic          pad_oe, pad_oe_s;
    logic [W-1:0]  raw_count;
    logic [WS-1:0] raw_count_s;
    logic          count_valid, count_valid_s, touched, touched_s;

    int  dly = 1;
    bit  glitch = 1'b0;
    int  n_checks = 0;
    int  n_err = 0;
    bit  finished = 1'b0;
    int  cyc = 0;

    always #2.5 clk = ~clk;

    touch_cycle_sensor #(.CNT_W(W), .WINDOW_CYC(WIN), .RECHARGE_CYC(RC)) uut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_oe(pad_oe),
        .touch_limit(thr), .raw_count(raw_count), .count_valid(count_valid), .touched(touched));

    touch_cycle_sensor #(.CNT_W(WS), .WINDOW_CYC(WIN), .RECHARGE_CYC(RC)) uut_sat (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_oe(pad_oe_s),
        .touch_limit(thr_s), .raw_count(raw_count_s), .count_valid(count_valid_s), .touched(touched_s));

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    // Behavioural reference: phase 0 drive-at-start, 1 listen, 2 drive-after-change, 3 report
    int ph, win, drv, mc, mcs, e_raw, e_raw_s;
    bit e_valid, e_touch, e_touch_s;
    bit seen[$];
    int drv_idx = 0;
    int dis = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            ph = 0; win = 0; drv = 0; mc = 0; mcs = 0;
            e_raw = 0; e_raw_s = 0; e_valid = 0; e_touch = 0; e_touch_s = 0;
            seen = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit chg, wend, pdone;
            chg  = (seen[1] != seen[2]);
            wend = (ph != 3) && (win == WIN - 1);
            if (ph == 3) begin
                e_raw = mc; e_raw_s = mcs;
                e_touch = (mc < int'(thr)); e_touch_s = (mcs < int'(thr_s));
                e_valid = 1; mc = 0; mcs = 0; win = 0; drv = 0; ph = 0;
            end else begin
                e_valid = 0;
                win++;
                if (ph == 1) begin
                    drv = 0;
                    if (chg) begin
                        if (mc < (1 << W) - 1) mc++;
                        if (mcs < (1 << WS) - 1) mcs++;
                    end
                    ph = wend ? 3 : (chg ? 2 : 1);
                end else begin
                    pdone = (drv == RC - 1);
                    drv = pdone ? 0 : drv + 1;
                    ph = wend ? 3 : (pdone ? 1 : ph);
                end
            end
            seen.push_front(pad_in);
            void'(seen.pop_back());
        end
        // every-cycle comparison
        check(pad_oe == ((ph == 0) || (ph == 2)), "R2 R3 R4", "pad_oe", int'(pad_oe), int'((ph == 0) || (ph == 2)));
        check(count_valid == e_valid, "R5 R9", "count_valid", int'(count_valid), int'(e_valid));
        check(int'(raw_count) == e_raw, "R7", "raw_count", int'(raw_count), e_raw);
        check(touched == e_touch, "R6", "touched", int'(touched), int'(e_touch));
        check(int'(raw_count_s) == e_raw_s, "R8", "narrow raw_count", int'(raw_count_s), e_raw_s);
        check(touched_s == e_touch_s, "R6", "narrow touched", int'(touched_s), int'(e_touch_s));
        // pad model: charged while driven, falls dly cycles after release
        if (pad_oe) begin
            pad_in = !(glitch && (drv_idx == 1));
            drv_idx++;
            dis = 0;
        end else begin
            drv_idx = 0;
            dis++;
            pad_in = (dis >= dly) ? 1'b0 : 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d cycles at most", cyc, 100000);
            finish_run();
        end
    end

    task automatic wait_valid(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!count_valid);
    endtask

    initial begin
        int gap, c1, c2, c3, hold_raw;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(pad_oe == 1'b1, "R1", "pad_oe in reset", int'(pad_oe), 1);
        check(raw_count == '0, "R1", "raw_count in reset", int'(raw_count), 0);
        check(touched == 1'b0, "R1", "touched in reset", int'(touched), 0);
        check(count_valid == 1'b0, "R1", "count_valid in reset", int'(count_valid), 0);
        rst_n <= 1'b1;

        // untouched pad
        wait_valid(gap);
        c1 = int'(raw_count);
        check(touched == 1'b0, "R6", "fast pad not touched", int'(touched), 0);
        check(int'(raw_count_s) == 7, "R8", "narrow counter saturated", int'(raw_count_s), 7);
        check(pad_oe == 1'b1, "R2", "pin driven at window start", int'(pad_oe), 1);
        glitch <= 1'b1;

        // bounce while driven must not add counts
        wait_valid(gap);
        check(int'(raw_count) == c1, "R4", "count with bounce while driven", int'(raw_count), c1);
        check(gap == WIN + 1, "R5", "strobe spacing", gap, WIN + 1);
        glitch <= 1'b0;
        dly <= 12;
        hold_raw = int'(raw_count);
        @(negedge clk);
        check(count_valid == 1'b0, "R9", "strobe one cycle", int'(count_valid), 0);
        check(int'(raw_count) == hold_raw, "R9", "raw_count held", int'(raw_count), hold_raw);

        // touched pad
        wait_valid(gap);
        c2 = int'(raw_count);
        check(c2 < c1, "R3", "slower pad lowers count", c2, c1 - 1);
        check(touched == 1'b1, "R6", "slow pad touched", int'(touched), 1);
        thr <= W'(c2);

        wait_valid(gap);
        check(int'(raw_count) == c2, "R7", "repeat window count", int'(raw_count), c2);
        check(touched == 1'b0, "R6", "count equal to limit", int'(touched), 0);
        thr <= W'(c2 + 1);

        wait_valid(gap);
        check(touched == 1'b1, "R6", "count one below limit", int'(touched), 1);
        dly <= 40;

        // heavy touch: narrow counter stays exact
        wait_valid(gap);
        c3 = int'(raw_count);
        check(int'(raw_count_s) == c3, "R8", "narrow count below ceiling", int'(raw_count_s), c3);
        check(touched_s == 1'b1, "R6", "narrow touched", int'(touched_s), 1);
        check(c3 < c2, "R3", "slowest pad lowest count", c3, c2 - 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule